// File: doc/BRIEF.md
# Soft-Start and Reset Release Sequencer

This block sequences the start-up of a switching regulator controller. It counts switching-cycle ticks, not clock cycles. While enabled it raises a current-limit code in equal steps from zero to full scale. It also arms undervoltage protection after a fixed number of cycles, and it keeps an active-low reset output asserted for a long fixed interval before releasing it.

The surrounding logic supplies a single-cycle `cyc_tick` pulse once per switching period and a `pgood` level from the output monitor. The block feeds `ilim_code` to the current-limit DAC and `uv_armed` to the undervoltage comparator path. `rst_out_n` goes to the system reset pin. Dropping `enable` is a shutdown: the reset output is pulled low at once, and every timer restarts from zero on the next enable.

Top module: `pwr_seq_softstart`

## Requirements
- R1: While `rst_n` is low, `ilim_code` is 0 and `uv_armed` and `rst_out_n` are both 0.
- R2: With `enable` high, `ilim_code` is 0 until 128 ticks have been counted. It then reads 63 from the 128th tick, 127 from the 256th, 191 from the 384th and 255 from the 512th. Each code is floor(k*255/4) for level k, where 255 is the full scale of the 8-bit code.
- R3: Once the code reaches 255 it stays at 255, however many further ticks arrive, until `enable` falls.
- R4: The code advances only on clock edges where `cyc_tick` is high. Clock cycles without a tick leave all outputs unchanged.
- R5: `uv_armed` is 0 until the 5000th tick after enable and is 1 from the edge that counts that tick.
- R6: `rst_out_n` stays 0 until the 32768th tick after enable.
- R7: After the reset interval has expired, `rst_out_n` equals `pgood` in the same cycle, without waiting for a clock edge. A loss of `pgood` pulls the output low again.
- R8: `enable` low forces `rst_out_n` to 0 in the same cycle, without waiting for a clock edge.
- R9: One clock edge after `enable` falls, `ilim_code` is 0 and `uv_armed` is 0. On re-enable all counts start again from zero.
- R10: Ticks that arrive while `enable` is low are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Regulator enable; low means shutdown |
| cyc_tick | input | 1 | One-clock pulse per switching cycle |
| pgood | input | 1 | Output-in-range indication |
| ilim_code | output | 8 | Current-limit DAC code |
| uv_armed | output | 1 | Undervoltage protection armed |
| rst_out_n | output | 1 | Active-low reset output |

## Verification
The code and `uv_armed` change on the same clock edge that samples the tick which completes a count. No register lies between the counters and the outputs. The bench therefore raises `cyc_tick` at a falling edge, holds it for exactly N falling edges, and checks at that last falling edge, after N sampling edges. For R7 and R8, `rst_out_n` responds with no clock at all, so those checks are made one time step after `pgood` or `enable` changes, before any rising edge. Disable clearing (R9) is checked one falling edge after `enable` drops.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  // DAC code for ramp level lvl out of nsteps, full scale = all ones
  function automatic int unsigned level_code(input int unsigned lvl,
                                             input int unsigned nsteps,
                                             input int unsigned code_w);
    int unsigned fs;
    fs = (1 << code_w) - 1;
    return (lvl * fs) / nsteps;
  endfunction

  // ramp level reached after cnt ticks, saturating at nsteps
  function automatic int unsigned level_of_count(input int unsigned cnt,
                                                 input int unsigned step_ticks,
                                                 input int unsigned nsteps);
    int unsigned l;
    l = cnt / step_ticks;
    return (l > nsteps) ? nsteps : l;
  endfunction

endpackage

// File: rtl/pwr_seq_tick_timer.sv
module pwr_seq_tick_timer #(
  parameter int LIMIT = 16,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  output logic [CW-1:0] count,
  output logic          done
);

  assign done = (count == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (!run)           count <= '0;
    else if (tick && !done)  count <= count + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (count == CW'(LIMIT)) || !$past(run) || !run); // R3

endmodule

// File: rtl/pwr_seq_ilim_ramp.sv
module pwr_seq_ilim_ramp
  import pwr_seq_pkg::*;
#(
  parameter int NSTEPS     = 4,
  parameter int STEP_TICKS = 128,
  parameter int CODE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  output logic [CODE_W-1:0] code,
  output logic              at_full
);

  localparam int RAMP_TICKS = NSTEPS * STEP_TICKS;
  localparam int RCW        = $clog2(RAMP_TICKS + 1);

  logic [RCW-1:0] ramp_cnt;
  logic           ramp_done;
  int unsigned    lvl;

  pwr_seq_tick_timer #(.LIMIT(RAMP_TICKS)) u_ramp_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick),
    .count (ramp_cnt),
    .done  (ramp_done)
  );

  always_comb begin
    lvl  = level_of_count(int'(ramp_cnt), STEP_TICKS, NSTEPS);
    code = CODE_W'(level_code(lvl, NSTEPS, CODE_W));
  end

  assign at_full = ramp_done;

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (at_full && run) |=> (code == {CODE_W{1'b1}}) || !run); // R3

endmodule

// File: rtl/pwr_seq_rst_gate.sv
module pwr_seq_rst_gate (
  input  logic enable,
  input  logic expired,
  input  logic pgood,
  output logic rst_out_n
);

  // combinational so that shutdown and power-good loss act at once
  assign rst_out_n = enable & expired & pgood;

endmodule

// File: rtl/pwr_seq_softstart.sv
module pwr_seq_softstart #(
  parameter int NSTEPS     = 4,
  parameter int STEP_TICKS = 128,
  parameter int CODE_W     = 8,
  parameter int UV_TICKS   = 5000,
  parameter int RST_TICKS  = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cyc_tick,
  input  logic              pgood,
  output logic [CODE_W-1:0] ilim_code,
  output logic              uv_armed,
  output logic              rst_out_n
);

  localparam int UCW = $clog2(UV_TICKS + 1);
  localparam int XCW = $clog2(RST_TICKS + 1);

  logic           ramp_full;
  logic [UCW-1:0] uv_cnt;
  logic [XCW-1:0] rst_cnt;
  logic           rst_expired;

  pwr_seq_ilim_ramp #(
    .NSTEPS(NSTEPS), .STEP_TICKS(STEP_TICKS), .CODE_W(CODE_W)
  ) u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (enable),
    .tick    (cyc_tick),
    .code    (ilim_code),
    .at_full (ramp_full)
  );

  pwr_seq_tick_timer #(.LIMIT(UV_TICKS)) u_uv_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (enable),
    .tick  (cyc_tick),
    .count (uv_cnt),
    .done  (uv_armed)
  );

  pwr_seq_tick_timer #(.LIMIT(RST_TICKS)) u_rst_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (enable),
    .tick  (cyc_tick),
    .count (rst_cnt),
    .done  (rst_expired)
  );

  pwr_seq_rst_gate u_rst_gate (
    .enable    (enable),
    .expired   (rst_expired),
    .pgood     (pgood),
    .rst_out_n (rst_out_n)
  );

  AST_RAMP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> (ilim_code >= $past(ilim_code))); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$past(cyc_tick)) |-> $stable(ilim_code)); // R4

  AST_CLEAR_ON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ((ilim_code == '0) && !uv_armed)); // R9

  AST_RST_AFTER_UV: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out_n |-> (uv_armed && ramp_full)); // R6

endmodule

// File: tb/pwr_seq_softstart_bench.sv
`timescale 1ns/1ps
module pwr_seq_softstart_bench;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       enable = 0;
  logic       cyc_tick = 0;
  logic       pgood = 0;
  logic [7:0] ilim_code;
  logic       uv_armed;
  logic       rst_out_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwr_seq_softstart u_pwr_seq_softstart (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cyc_tick(cyc_tick),
    .pgood(pgood), .ilim_code(ilim_code), .uv_armed(uv_armed),
    .rst_out_n(rst_out_n)
  );

  function automatic int exp_code(input int lvl);
    case (lvl)
      0: return 0;
      1: return 63;
      2: return 127;
      3: return 191;
      default: return 255;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      cyc_tick = 1;
      repeat (n) @(negedge clk);
      cyc_tick = 0;
    end
  endtask

  task automatic turn_on();
    @(negedge clk); enable = 1;
  endtask

  task automatic turn_off();
    @(negedge clk); enable = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0; enable = 1; cyc_tick = 1; pgood = 1;
    repeat (3) @(negedge clk);
    chk("R1 code", ilim_code, 0);
    chk("R1 uv", uv_armed, 0);
    chk("R1 rst", rst_out_n, 0);
    enable = 0; cyc_tick = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_ramp();
    turn_on();
    for (int k = 1; k <= 4; k++) begin
      ticks(127);
      chk("R2 before step", ilim_code, exp_code(k - 1));
      ticks(1);
      chk("R2 at step", ilim_code, exp_code(k));
    end
    ticks(300);
    chk("R3 hold full", ilim_code, 255);
    turn_off();
    chk("R9 code cleared", ilim_code, 0);
  endtask

  task automatic t_sparse();
    turn_on();
    for (int i = 0; i < 127; i++) begin
      ticks(1);
      repeat (2) @(negedge clk);
    end
    repeat (50) @(negedge clk);
    chk("R4 no tick no step", ilim_code, 0);
    ticks(1);
    chk("R4 sparse 128th tick", ilim_code, 63);
    repeat (40) @(negedge clk);
    chk("R4 idle hold", ilim_code, 63);
    turn_off();
  endtask

  task automatic t_restart();
    turn_on();
    ticks(300);
    chk("R9 mid ramp", ilim_code, 127);
    turn_off();
    chk("R9 cleared", ilim_code, 0);
    turn_on();
    ticks(127);
    chk("R9 restart from zero", ilim_code, 0);
    ticks(1);
    chk("R9 restart first step", ilim_code, 63);
    turn_off();
  endtask

  task automatic t_ignore_off();
    enable = 0;
    ticks(600);
    chk("R10 code while off", ilim_code, 0);
    turn_on();
    ticks(127);
    chk("R10 off ticks not counted", ilim_code, 0);
    turn_off();
  endtask

  task automatic t_timers();
    pgood = 1;
    turn_on();
    ticks(4999);
    chk("R5 uv before", uv_armed, 0);
    ticks(1);
    chk("R5 uv at 5000", uv_armed, 1);
    chk("R6 rst still low", rst_out_n, 0);
    ticks(32767 - 5000);
    chk("R6 rst before expiry", rst_out_n, 0);
    ticks(1);
    chk("R6 rst released", rst_out_n, 1);
    pgood = 0; #0.5;
    chk("R7 pgood loss", rst_out_n, 0);
    pgood = 1; #0.5;
    chk("R7 pgood back", rst_out_n, 1);
    @(negedge clk);
    enable = 0; #0.5;
    chk("R8 shutdown immediate", rst_out_n, 0);
    @(negedge clk);
    chk("R9 uv cleared", uv_armed, 0);
    enable = 1;
    ticks(5);
    chk("R9 rst low after restart", rst_out_n, 0);
    turn_off();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_ramp();
    t_sparse();
    t_restart();
    t_ignore_off();
    t_timers();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule